// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog Timer

This block is a per-core watchdog that escalates when software stops servicing it. Software writes a configuration word that holds a two-bit mode and a length. The block then counts down one period at a time. If a period passes with no poke, it raises an interrupt. If the next period also passes with no poke, it raises a non-maskable interrupt (NMI). One period after that, it issues a single-cycle soft-reset request. Each enabled stage starts one full period after the stage before it. Any poke restarts the countdown and returns the block to its first counting stage. A readback word shows which stages have been reached, so an NMI handler can tell a watchdog NMI apart from other NMIs.

The count runs on two levels. A prescaler of `PRE_W` bits produces one tick every 2^PRE_W clocks. A decrementer of `LEN_W+LOW_W` bits steps once per tick. The length field loads only the upper `LEN_W` bits of the decrementer, and the low `LOW_W` bits load as zero. With the default parameters (16, 8, 8), one period is length × 65536 clocks. Each core instantiates its own copy.

The stage controller has six states:

| State | Meaning |
|---|---|
| `ST_OFF` | Disabled. |
| `ST_RUN` | Counting the first period. |
| `ST_IRQ` | Interrupt raised. |
| `ST_NMI` | NMI raised. |
| `ST_FIRE` | The one cycle in which the soft-reset request is issued. |
| `ST_HOLD` | Resting after the soft-reset request. |

Transitions:

- **Period expiry:** `ST_RUN`→`ST_IRQ`, `ST_IRQ`→`ST_NMI` (mode 2 or 3 only), `ST_NMI`→`ST_FIRE` (mode 3 only).
- **Unconditional:** `ST_FIRE`→`ST_HOLD` on the next clock.
- **Configuration write:** from any state to `ST_OFF` if the new mode is 0, otherwise to `ST_RUN`.
- **Poke:** from any state except `ST_OFF` to `ST_RUN`.

A configuration write takes priority over a poke, and a poke takes priority over an expiry.

Top module: `esc_watchdog`

## Requirements
- R1: After reset, all three outputs are low, the readback word is zero and the block stays disabled with no outputs, however long it runs.
- R2: With a nonzero mode and a nonzero length L, `irq_o` first goes high exactly L·2^LOW_W·2^PRE_W clocks after the clock edge that accepts the configuration write.
- R3: In modes 2 and 3, `nmi_o` goes high exactly one period after `irq_o` rose, and `irq_o` stays high alongside it.
- R4: In mode 3, `srst_o` is high for exactly one cycle, one period after `nmi_o` rose. After that, `irq_o` and `nmi_o` stay high and no further reset pulse occurs until a poke or a configuration write.
- R5: In mode 1, only `irq_o` ever asserts, and escalation stops there.
- R6: In mode 2, `irq_o` and `nmi_o` assert but `srst_o` never does.
- R7: A configuration word with mode 0 disables the block. All outputs drop on the edge that accepts the write and stay low afterwards.
- R8: A poke while enabled clears `irq_o` and `nmi_o` on the accepting edge and restarts a full period. The prescaler is cleared as well, so the interrupt follows exactly one period after the poke.
- R9: Readback layout: bit 0 is set once the interrupt stage is reached, bit 1 once the NMI stage is reached, bits 3:2 hold the mode, and bits LEN_W+3:4 hold the length. The write word carries the mode in bits 1:0 and the length in bits LEN_W+1:2.
- R10: A length of 0 with a nonzero mode gives the minimum period of one tick (2^PRE_W clocks). The countdown never stalls or wraps.
- R11: A configuration write during a period restarts counting at once, using the new length for a full period. The old countdown has no effect.
- R12: A poke while disabled has no effect on the outputs or the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | LEN_W+2 | Configuration word: {length, mode} |
| poke_we | input | 1 | Poke strobe; restarts the countdown |
| cfg_rdata | output | LEN_W+4 | Readback: {length, mode, NMI reached, interrupt reached} |
| irq_o | output | 1 | Interrupt level |
| nmi_o | output | 1 | NMI level |
| srst_o | output | 1 | One-cycle soft-reset request |

## Verification
Take T as one period and k as the clock edge that accepts a configuration write or poke. Every result comes straight from the stage register, so each is due on a fixed edge:

- `irq_o` at edge k+T.
- `nmi_o` at edge k+2T.
- `srst_o` at edge k+3T only, low again at edge k+3T+1.
- Clearing by a poke or a mode-0 write at edge k itself.

The bench drives strobes on falling edges and samples on the falling edge after each rising edge. In the sweep it compares every cycle from edge k to edge k+3T+2 against these arithmetic expectations, for every length and every enabled mode of a reduced configuration with T = 16·L clocks.

// File: rtl/esc_wdt_pkg.sv
package esc_wdt_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RUN,
        ST_IRQ,
        ST_NMI,
        ST_FIRE,
        ST_HOLD
    } wdt_state_e;

    localparam logic [1:0] MODE_OFF  = 2'd0;
    localparam logic [1:0] MODE_IRQ  = 2'd1;
    localparam logic [1:0] MODE_NMI  = 2'd2;
    localparam logic [1:0] MODE_FULL = 2'd3;

endpackage

// File: rtl/esc_wdt_prescaler.sv
module esc_wdt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic tick
);

    generate
        if (PRE_W == 0) begin : g_direct
            // No division: every enabled clock is a tick.
            assign tick = en;
        end else begin : g_count
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clear) begin
                    pre_q <= '0;
                end else if (en) begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = en && (pre_q == {PRE_W{1'b1}});
        end
    endgenerate

endmodule

// File: rtl/esc_wdt_decrementer.sv
module esc_wdt_decrementer #(
    parameter int LEN_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic [LEN_W-1:0] reload_len,
    input  logic             tick,
    output logic             expire
);

    localparam int DEC_W = LEN_W + LOW_W;
    localparam logic [DEC_W-1:0] LOAD_MAX = DEC_W'(2**LEN_W - 1) << LOW_W;

    logic [DEC_W-1:0] dec_q;

    // Length fills the upper bits; the low bits start at zero.
    function automatic logic [DEC_W-1:0] start_val(input logic [LEN_W-1:0] len);
        return DEC_W'(len) << LOW_W;
    endfunction

    // A value of 0 or 1 ends the period, so a zero length lasts one tick.
    assign expire = tick && (dec_q <= DEC_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else if (load) begin
            dec_q <= start_val(load_len);
        end else if (tick) begin
            if (dec_q <= DEC_W'(1)) begin
                dec_q <= start_val(reload_len);
            end else begin
                dec_q <= dec_q - 1'b1;
            end
        end
    end

    // R10: the count never wraps above the largest loadable value
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q <= LOAD_MAX);

endmodule

// File: rtl/esc_wdt_stage_fsm.sv
module esc_wdt_stage_fsm
    import esc_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] new_mode,
    input  logic       poke_we,
    input  logic [1:0] mode_q,
    input  logic       expire,
    output logic       count_en,
    output logic       irq_o,
    output logic       nmi_o,
    output logic       srst_o,
    output logic       irq_seen,
    output logic       nmi_seen
);

    wdt_state_e state_q, state_d;

    // State register and next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = ST_OFF;
            ST_RUN:  if (expire) state_d = ST_IRQ;
            ST_IRQ:  if (expire) state_d = ST_NMI;
            ST_NMI:  if (expire) state_d = ST_FIRE;
            ST_FIRE: state_d = ST_HOLD;
            ST_HOLD: state_d = ST_HOLD;
            default: state_d = ST_OFF;
        endcase
        if (cfg_we) begin
            state_d = (new_mode == MODE_OFF) ? ST_OFF : ST_RUN;
        end else if (poke_we && (state_q != ST_OFF)) begin
            state_d = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        count_en = 1'b0;
        irq_o    = 1'b0;
        nmi_o    = 1'b0;
        srst_o   = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_RUN:  count_en = 1'b1;
            ST_IRQ: begin
                irq_o    = 1'b1;
                count_en = (mode_q == MODE_NMI) || (mode_q == MODE_FULL);
            end
            ST_NMI: begin
                irq_o    = 1'b1;
                nmi_o    = 1'b1;
                count_en = (mode_q == MODE_FULL);
            end
            ST_FIRE: begin
                irq_o  = 1'b1;
                nmi_o  = 1'b1;
                srst_o = 1'b1;
            end
            ST_HOLD: begin
                irq_o = 1'b1;
                nmi_o = 1'b1;
            end
            default: ;
        endcase
        irq_seen = irq_o;
        nmi_seen = nmi_o;
    end

    // R4: the reset request never lasts more than one cycle
    p_srst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> !srst_o);

    // R3: NMI only rises while the interrupt was already up
    p_nmi_after_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> $past(irq_o));

    // R5: interrupt-only mode never reaches NMI
    p_mode1_no_nmi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IRQ) |-> !nmi_o);

    // R6: mode 2 never requests a reset
    p_mode2_no_srst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NMI) |-> !srst_o);

    // R7: disabled means silent
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) |-> (!irq_o && !nmi_o && !srst_o));

endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
    import esc_wdt_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int PRE_W = 8,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [LEN_W+1:0] cfg_wdata,
    input  logic             poke_we,
    output logic [LEN_W+3:0] cfg_rdata,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             srst_o
);

    logic [1:0]       mode_q;
    logic [LEN_W-1:0] len_q;
    logic [1:0]       new_mode;
    logic [LEN_W-1:0] new_len;
    logic [LEN_W-1:0] load_len;
    logic             restart;
    logic             count_en;
    logic             tick;
    logic             expire;
    logic             irq_seen;
    logic             nmi_seen;

    assign new_mode = cfg_wdata[1:0];
    assign new_len  = cfg_wdata[LEN_W+1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            len_q  <= '0;
        end else if (cfg_we) begin
            mode_q <= new_mode;
            len_q  <= new_len;
        end
    end

    // Any write or live poke starts a fresh, full period.
    assign restart  = cfg_we || (poke_we && (mode_q != MODE_OFF));
    assign load_len = cfg_we ? new_len : len_q;

    esc_wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .en    (count_en),
        .tick  (tick)
    );

    esc_wdt_decrementer #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (restart),
        .load_len   (load_len),
        .reload_len (len_q),
        .tick       (tick),
        .expire     (expire)
    );

    esc_wdt_stage_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .new_mode (new_mode),
        .poke_we  (poke_we),
        .mode_q   (mode_q),
        .expire   (expire),
        .count_en (count_en),
        .irq_o    (irq_o),
        .nmi_o    (nmi_o),
        .srst_o   (srst_o),
        .irq_seen (irq_seen),
        .nmi_seen (nmi_seen)
    );

    assign cfg_rdata = {len_q, mode_q, nmi_seen, irq_seen};

    // R8: a live poke leaves no interrupt pending on the next cycle
    p_poke_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (poke_we && !cfg_we && (mode_q != MODE_OFF)) |=> (!irq_o && !nmi_o));

endmodule

// File: tb/test_esc_watchdog.sv
`timescale 1ns/1ps
module test_esc_watchdog;

    localparam int LW = 4;
    localparam int PW = 2;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          poke_we = 1'b0;
    logic [LW+1:0] cfg_wdata = '0;
    logic [LW+3:0] cfg_rdata;
    logic          irq, nmi, srst;
    int            checks = 0;
    int            failures = 0;
    bit            finished = 1'b0;

    always #2 clk = ~clk;

    esc_watchdog #(.LEN_W(LW), .PRE_W(PW), .LOW_W(BW)) i_esc_watchdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .poke_we   (poke_we),
        .cfg_rdata (cfg_rdata),
        .irq_o     (irq),
        .nmi_o     (nmi),
        .srst_o    (srst)
    );

    function automatic int period(input int len);
        return ((len == 0) ? 1 : len * (1 << BW)) * (1 << PW);
    endfunction

    function automatic logic [31:0] exp_rd(input int len, input int mode, input bit i, input bit n);
        return 32'({LW'(len), 2'(mode), n, i});
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int mode, input int len);
        @(negedge clk);
        cfg_wdata = {LW'(len), 2'(mode)};
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic poke();
        @(negedge clk);
        poke_we = 1'b1;
        @(negedge clk);
        poke_we = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t;
        logic acc;

        // R1 reset state
        step(3);
        chk("R1 outputs in reset", {29'd0, irq, nmi, srst}, 32'd0);
        chk("R1 readback in reset", 32'(cfg_rdata), 32'd0);
        rst_n = 1'b1;
        step(60);
        chk("R1 idle outputs", {29'd0, irq, nmi, srst}, 32'd0);
        chk("R1 idle readback", 32'(cfg_rdata), 32'd0);

        // Sweep: every enabled mode, every length (R2 R3 R4 R5 R6 R9 R10)
        for (int mode = 1; mode <= 3; mode++) begin
            for (int len = 0; len < 16; len++) begin
                write_cfg(mode, len);
                t = period(len);
                for (int j = 0; j <= 3 * t + 2; j++) begin
                    bit ei, en, es;
                    if (j > 0) step(1);
                    ei = (j >= t);
                    en = (mode >= 2) && (j >= 2 * t);
                    es = (mode == 3) && (j == 3 * t);
                    chk((len == 0) ? "R10 irq" : ((mode == 1) ? "R5 irq" : "R2 irq"), 32'(irq), 32'(ei));
                    chk((mode == 2) ? "R6 nmi" : ((mode == 1) ? "R5 nmi" : "R3 nmi"), 32'(nmi), 32'(en));
                    chk((mode == 3) ? "R4 srst" : ((mode == 2) ? "R6 srst" : "R5 srst"), 32'(srst), 32'(es));
                    chk("R9 readback", 32'(cfg_rdata), exp_rd(len, mode, ei, en));
                end
            end
        end

        // R4 hold after the reset request
        acc = 1'b0;
        for (int j = 0; j < 100; j++) begin
            step(1);
            acc = acc | srst;
        end
        chk("R4 no second pulse", 32'(acc), 32'd0);
        chk("R4 hold levels", {30'd0, irq, nmi}, 32'd3);

        // R8 poke clears and restarts
        write_cfg(3, 2);
        t = period(2);
        step(t + 3);
        chk("R8 irq before poke", 32'(irq), 32'd1);
        poke();
        chk("R8 irq cleared", 32'(irq), 32'd0);
        step(t - 1);
        chk("R8 no early irq", 32'(irq), 32'd0);
        step(1);
        chk("R8 irq one period after poke", 32'(irq), 32'd1);
        step(t);
        chk("R8 nmi before poke", 32'(nmi), 32'd1);
        poke();
        chk("R8 nmi cleared", {30'd0, irq, nmi}, 32'd0);
        chk("R8 readback cleared", 32'(cfg_rdata), exp_rd(2, 3, 1'b0, 1'b0));

        // R11 reconfigure mid-period
        write_cfg(1, 3);
        step(20);
        write_cfg(1, 1);
        t = period(1);
        step(t - 1);
        chk("R11 no irq before new period", 32'(irq), 32'd0);
        step(1);
        chk("R11 irq at new period", 32'(irq), 32'd1);

        // R7 disable clears everything
        write_cfg(3, 1);
        t = period(1);
        step(2 * t + 1);
        chk("R7 nmi before disable", 32'(nmi), 32'd1);
        write_cfg(0, 1);
        chk("R7 outputs dropped", {29'd0, irq, nmi, srst}, 32'd0);
        chk("R7 readback", 32'(cfg_rdata), exp_rd(1, 0, 1'b0, 1'b0));
        acc = 1'b0;
        for (int j = 0; j < 300; j++) begin
            step(1);
            acc = acc | irq | nmi | srst;
        end
        chk("R7 silent while disabled", 32'(acc), 32'd0);

        // R12 poke while disabled
        poke();
        acc = 1'b0;
        for (int j = 0; j < 300; j++) begin
            step(1);
            acc = acc | irq | nmi | srst;
        end
        chk("R12 outputs after poke", 32'(acc), 32'd0);
        chk("R12 readback after poke", 32'(cfg_rdata), exp_rd(1, 0, 1'b0, 1'b0));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule